// File: doc/BRIEF.md
# Port Interrupt Status and Line Steering Unit

This block holds the interrupt state of one port of a storage host controller. Hardware event pulses set bits of a twelve-bit status word, and software clears them by writing ones through a simple 32-bit register bus. An enable mask decides which status bits may raise the port interrupt. Software changes that mask through two separate addresses: one turns bits on and the other turns them off. Three status bits skip the mask. Each of them is passed on only while its own external threshold-qualify input is high.

The port interrupt is a level. A two-bit steering field routes it to exactly one of four shared interrupt lines. The status bit for the ready condition is edge-triggered: it records a rising edge of the port-ready level, not the level itself.

The unit also keeps a 32-bit upper-address word for 64-bit command activation. It issues this word when the low half of the activation register is written while the 32-bit activation control input is set.

Top module: `port_irq_unit`

## Requirements
- R1: Status bit 2 sets only on a 0-to-1 change of `port_rdy`. After software clears it, it stays clear while `port_rdy` stays high, and it sets again only after `port_rdy` falls and rises again. `evt_set[2]` has no effect.
- R2: The status word sits at offset 0x1008, in bits 11:0. Writing 1 to a bit clears it, writing 0 leaves it unchanged, and writes to bits 31:12 have no effect.
- R3: A 1 written at offset 0x1010 sets the matching enable bit. A 1 written at offset 0x1014 clears it. Bits written as 0 keep their value.
- R4: A read at 0x1010 and a read at 0x1014 return the same word: the steering field in bits 31:30 and the enable bits in bits 11:0.
- R5: Enable bits exist only at positions 11 and 7:0. Positions 29:12 and 10:8 of the enable word read as 0 and ignore writes.
- R6: Status bits 8, 9 and 10 have no enable bit. Each one drives the interrupt only while its own input `thr_qual[0]`, `thr_qual[1]` or `thr_qual[2]` is high.
- R7: A write at either enable offset loads the steering field from bits 31:30. Field value 00 selects `irq_line[0]`, 01 selects `irq_line[1]`, 10 selects `irq_line[2]` and 11 selects `irq_line[3]`. The three lines that are not selected stay low.
- R8: After reset, the status word, the enable word, the steering field and the upper-address word all read 0x0000_0000.
- R9: Offset 0x101C is a 32-bit read/write upper-address word. One cycle after `act_lo_wr` is high while `act64_en` is high, `act_upper_vld` is 1 and `act_upper` holds the word. If `act64_en` is low, `act_upper_vld` stays 0.
- R10: The interrupt is the OR of the enabled status bits and the qualified threshold bits. It appears on the selected line one clock after the status, enable or qualify state that produces it.
- R11: If a hardware set and a write-1-to-clear hit the same status bit in the same cycle, the bit ends at 1.
- R12: `bus_rdata` is registered. It shows the addressed word one cycle after `bus_rd`, and it is 0 when there was no read or the read hit an unmapped offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Single-cycle register write strobe |
| bus_rd | input | 1 | Single-cycle register read strobe |
| bus_addr | input | 16 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| evt_set | input | 12 | Hardware set pulses, one per status bit (bit 2 unused) |
| port_rdy | input | 1 | Port-ready level |
| thr_qual | input | 3 | Threshold qualifiers for status bits 8..10 |
| act_lo_wr | input | 1 | Low half of the command activation register written |
| act64_en | input | 1 | 32-bit activation control bit from the port control register |
| act_upper_vld | output | 1 | Upper activation word valid |
| act_upper | output | 32 | Upper activation word |
| irq_line | output | 4 | Shared interrupt lines A..D |

## Verification
The assertions assume that every input is synchronous to `clk` and changes only between rising edges. They also assume that `port_rdy` is a clean level with no glitches, and that event inputs are single-cycle pulses; the properties on rising edges and on set priority depend on this. The bench drives all inputs on the falling edge and holds each for exactly one clock. It returns every strobe and pulse to zero between operations, so no input changes on an active edge and no level is left active by accident.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int OFS_W = 16;
  localparam logic [OFS_W-1:0] OFS_STAT  = 16'h1008;
  localparam logic [OFS_W-1:0] OFS_ENSET = 16'h1010;
  localparam logic [OFS_W-1:0] OFS_ENCLR = 16'h1014;
  localparam logic [OFS_W-1:0] OFS_UPPER = 16'h101C;
endpackage

// File: rtl/pirq_status.sv
module pirq_status #(
  parameter int STAT_W  = 12,
  parameter int RDY_BIT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] evt_set,
  input  logic [STAT_W-1:0] clr_mask,
  input  logic              port_rdy,
  output logic [STAT_W-1:0] stat_q
);
  logic              rdy_q;
  logic              rdy_rise;
  logic [STAT_W-1:0] set_vec;

  assign rdy_rise = port_rdy & ~rdy_q;

  for (genvar i = 0; i < STAT_W; i++) begin : g_set
    if (i == RDY_BIT) begin : g_rdy
      assign set_vec[i] = rdy_rise;
    end else begin : g_evt
      assign set_vec[i] = evt_set[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_q  <= 1'b0;
      stat_q <= '0;
    end else begin
      rdy_q  <= port_rdy;
      stat_q <= (stat_q & ~clr_mask) | set_vec;
    end
  end
endmodule

// File: rtl/pirq_mask.sv
module pirq_mask #(
  parameter int              STAT_W  = 12,
  parameter int              SEL_W   = 2,
  parameter logic [STAT_W-1:0] EN_MASK = 12'h8FF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_wr,
  input  logic              clr_wr,
  input  logic [STAT_W-1:0] wbits,
  input  logic [SEL_W-1:0]  wsel,
  output logic [STAT_W-1:0] en_q,
  output logic [SEL_W-1:0]  sel_q
);
  logic [STAT_W-1:0] wmasked;
  assign wmasked = wbits & EN_MASK;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      sel_q <= '0;
    end else begin
      if (set_wr) en_q <= en_q | wmasked;
      else if (clr_wr) en_q <= en_q & ~wmasked;
      if (set_wr || clr_wr) sel_q <= wsel;
    end
  end
endmodule

// File: rtl/pirq_route.sv
module pirq_route #(
  parameter int STAT_W = 12,
  parameter int SEL_W  = 2,
  parameter int LINES  = 4,
  parameter int THR_LO = 8,
  parameter int THR_N  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] stat,
  input  logic [STAT_W-1:0] en,
  input  logic [THR_N-1:0]  thr_qual,
  input  logic [SEL_W-1:0]  sel,
  output logic [LINES-1:0]  irq_line
);
  logic pend;
  assign pend = (|(stat & en)) | (|(stat[THR_LO +: THR_N] & thr_qual));

  for (genvar l = 0; l < LINES; l++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) irq_line[l] <= 1'b0;
      else     irq_line[l] <= pend && (sel == SEL_W'(l));
    end
  end
endmodule

// File: rtl/port_irq_unit.sv
module port_irq_unit #(
  parameter int              DATA_W  = 32,
  parameter int              ADDR_W  = 16,
  parameter int              STAT_W  = 12,
  parameter int              LINES   = 4,
  parameter int              RDY_BIT = 2,
  parameter int              THR_LO  = 8,
  parameter int              THR_N   = 3,
  parameter logic [STAT_W-1:0] EN_MASK = 12'h8FF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [STAT_W-1:0] evt_set,
  input  logic              port_rdy,
  input  logic [THR_N-1:0]  thr_qual,
  input  logic              act_lo_wr,
  input  logic              act64_en,
  output logic              act_upper_vld,
  output logic [DATA_W-1:0] act_upper,
  output logic [LINES-1:0]  irq_line
);
  import pirq_pkg::*;

  localparam int SEL_W = $clog2(LINES);
  localparam int PAD_W = DATA_W - SEL_W - STAT_W;

  logic              hit_stat, hit_set, hit_clr, hit_up;
  logic [STAT_W-1:0] stat_q, en_q, clr_mask;
  logic [SEL_W-1:0]  sel_q;
  logic [DATA_W-1:0] upper_q, rd_mux;

  assign hit_stat = (bus_addr == ADDR_W'(OFS_STAT));
  assign hit_set  = (bus_addr == ADDR_W'(OFS_ENSET));
  assign hit_clr  = (bus_addr == ADDR_W'(OFS_ENCLR));
  assign hit_up   = (bus_addr == ADDR_W'(OFS_UPPER));
  assign clr_mask = (bus_wr && hit_stat) ? bus_wdata[STAT_W-1:0] : '0;

  pirq_status #(.STAT_W(STAT_W), .RDY_BIT(RDY_BIT)) u_stat (
    .clk(clk), .rst(rst), .evt_set(evt_set), .clr_mask(clr_mask),
    .port_rdy(port_rdy), .stat_q(stat_q)
  );

  pirq_mask #(.STAT_W(STAT_W), .SEL_W(SEL_W), .EN_MASK(EN_MASK)) u_mask (
    .clk(clk), .rst(rst), .set_wr(bus_wr && hit_set), .clr_wr(bus_wr && hit_clr),
    .wbits(bus_wdata[STAT_W-1:0]), .wsel(bus_wdata[DATA_W-1 -: SEL_W]),
    .en_q(en_q), .sel_q(sel_q)
  );

  pirq_route #(.STAT_W(STAT_W), .SEL_W(SEL_W), .LINES(LINES),
               .THR_LO(THR_LO), .THR_N(THR_N)) u_route (
    .clk(clk), .rst(rst), .stat(stat_q), .en(en_q), .thr_qual(thr_qual),
    .sel(sel_q), .irq_line(irq_line)
  );

  always_comb begin
    rd_mux = '0;
    if (hit_stat)               rd_mux = {{(DATA_W-STAT_W){1'b0}}, stat_q};
    else if (hit_set || hit_clr) rd_mux = {sel_q, {PAD_W{1'b0}}, en_q};
    else if (hit_up)            rd_mux = upper_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      upper_q       <= '0;
      bus_rdata     <= '0;
      act_upper_vld <= 1'b0;
      act_upper     <= '0;
    end else begin
      if (bus_wr && hit_up) upper_q <= bus_wdata;
      bus_rdata     <= bus_rd ? rd_mux : '0;
      act_upper_vld <= act_lo_wr && act64_en;
      if (act_lo_wr && act64_en) act_upper <= upper_q;
    end
  end
endmodule

// File: rtl/pirq_checker.sv
module pirq_checker #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16,
  parameter int STAT_W = 12,
  parameter int LINES  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [STAT_W-1:0] evt_set,
  input logic              port_rdy,
  input logic              act_lo_wr,
  input logic              act64_en,
  input logic              act_upper_vld,
  input logic [LINES-1:0]  irq_line,
  input logic [STAT_W-1:0] stat
);
  import pirq_pkg::*;

  AST_ONE_LINE: assert property (@(posedge clk) disable iff (rst) $onehot0(irq_line)); // R7
  AST_RDY_RISE: assert property (@(posedge clk) disable iff (rst) $rose(stat[2]) |-> $past(port_rdy)); // R1
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst) evt_set[0] |=> stat[0]); // R11
  AST_RD_IDLE: assert property (@(posedge clk) disable iff (rst) !bus_rd |=> bus_rdata == '0); // R12
  AST_RESV_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (bus_addr == ADDR_W'(OFS_ENSET) || bus_addr == ADDR_W'(OFS_ENCLR)))
    |=> (bus_rdata[29:12] == '0 && bus_rdata[10:8] == '0)); // R5
  AST_VLD_GATE: assert property (@(posedge clk) disable iff (rst)
    act_upper_vld |-> $past(act_lo_wr && act64_en)); // R9
  AST_QUIET: assert property (@(posedge clk) disable iff (rst) stat == '0 |=> irq_line == '0); // R10
endmodule

bind port_irq_unit pirq_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .STAT_W(STAT_W), .LINES(LINES)) u_chk (
  .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .evt_set(evt_set), .port_rdy(port_rdy), .act_lo_wr(act_lo_wr), .act64_en(act64_en),
  .act_upper_vld(act_upper_vld), .irq_line(irq_line), .stat(stat_q)
);

// File: tb/sim_port_irq_unit.sv
`timescale 1ns/1ps
module sim_port_irq_unit;
  logic        clk = 1'b0, rst = 1'b1;
  logic        bus_wr = 0, bus_rd = 0, port_rdy = 0, act_lo_wr = 0, act64_en = 0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [11:0] evt_set = '0;
  logic [2:0]  thr_qual = '0;
  logic [31:0] bus_rdata, act_upper;
  logic        act_upper_vld;
  logic [3:0]  irq_line;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  port_irq_unit u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_set(evt_set), .port_rdy(port_rdy),
    .thr_qual(thr_qual), .act_lo_wr(act_lo_wr), .act64_en(act64_en),
    .act_upper_vld(act_upper_vld), .act_upper(act_upper), .irq_line(irq_line)
  );

  typedef struct packed {
    logic [1:0]  op;   // 0 idle, 1 write, 2 read+check, 3 irq check
    logic [15:0] addr;
    logic [31:0] data;
    logic [11:0] evt;
    logic [2:0]  thr;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 35;
  localparam vec_t TBL [NV] = '{
    '{2'd2, 16'h1008, 32'h0,        12'h000, 3'd0, 32'h0,        4'd8},  // R8
    '{2'd2, 16'h1010, 32'h0,        12'h000, 3'd0, 32'h0,        4'd8},  // R8
    '{2'd0, 16'h0,    32'h0,        12'h004, 3'd0, 32'h0,        4'd1},
    '{2'd2, 16'h1008, 32'h0,        12'h000, 3'd0, 32'h0,        4'd1},  // R1 evt bit2 ignored
    '{2'd1, 16'h1010, 32'hFFFFFFFF, 12'h000, 3'd0, 32'h0,        4'd3},
    '{2'd2, 16'h1010, 32'h0,        12'h000, 3'd0, 32'hC00008FF, 4'd3},  // R3
    '{2'd2, 16'h1014, 32'h0,        12'h000, 3'd0, 32'hC00008FF, 4'd4},  // R4
    '{2'd1, 16'h1014, 32'h000000F0, 12'h000, 3'd0, 32'h0,        4'd3},
    '{2'd2, 16'h1010, 32'h0,        12'h000, 3'd0, 32'h0000080F, 4'd3},  // R3
    '{2'd0, 16'h0,    32'h0,        12'h001, 3'd0, 32'h0,        4'd10},
    '{2'd3, 16'h0,    32'h0,        12'h000, 3'd0, 32'h1,        4'd10}, // R10
    '{2'd2, 16'h1008, 32'h0,        12'h000, 3'd0, 32'h1,        4'd2},  // R2
    '{2'd1, 16'h1008, 32'hFFFFF000, 12'h000, 3'd0, 32'h0,        4'd2},
    '{2'd2, 16'h1008, 32'h0,        12'h000, 3'd0, 32'h1,        4'd2},  // R2 zeros keep
    '{2'd1, 16'h1008, 32'h1,        12'h000, 3'd0, 32'h0,        4'd2},
    '{2'd2, 16'h1008, 32'h0,        12'h000, 3'd0, 32'h0,        4'd2},  // R2 cleared
    '{2'd3, 16'h0,    32'h0,        12'h000, 3'd0, 32'h0,        4'd10}, // R10
    '{2'd1, 16'h1010, 32'h80000000, 12'h000, 3'd0, 32'h0,        4'd7},
    '{2'd0, 16'h0,    32'h0,        12'h002, 3'd0, 32'h0,        4'd7},
    '{2'd3, 16'h0,    32'h0,        12'h000, 3'd0, 32'h4,        4'd7},  // R7 line C
    '{2'd1, 16'h1008, 32'h2,        12'h000, 3'd0, 32'h0,        4'd2},
    '{2'd0, 16'h0,    32'h0,        12'h100, 3'd0, 32'h0,        4'd6},
    '{2'd3, 16'h0,    32'h0,        12'h000, 3'd0, 32'h0,        4'd6},  // R6 unqualified
    '{2'd3, 16'h0,    32'h0,        12'h000, 3'd1, 32'h4,        4'd6},  // R6 qualified
    '{2'd3, 16'h0,    32'h0,        12'h000, 3'd2, 32'h0,        4'd6},  // R6 other qualifier
    '{2'd1, 16'h1008, 32'h100,      12'h000, 3'd0, 32'h0,        4'd2},
    '{2'd0, 16'h0,    32'h0,        12'h010, 3'd0, 32'h0,        4'd10},
    '{2'd3, 16'h0,    32'h0,        12'h000, 3'd0, 32'h0,        4'd10}, // R10 masked
    '{2'd2, 16'h1008, 32'h0,        12'h000, 3'd0, 32'h10,       4'd10},
    '{2'd1, 16'h1008, 32'h10,       12'h000, 3'd0, 32'h0,        4'd2},
    '{2'd1, 16'h101C, 32'h12345678, 12'h000, 3'd0, 32'h0,        4'd9},
    '{2'd2, 16'h101C, 32'h0,        12'h000, 3'd0, 32'h12345678, 4'd9},  // R9
    '{2'd1, 16'h1010, 32'h00007700, 12'h000, 3'd0, 32'h0,        4'd5},
    '{2'd2, 16'h1014, 32'h0,        12'h000, 3'd0, 32'h0000080F, 4'd5},  // R5
    '{2'd2, 16'h1000, 32'h0,        12'h000, 3'd0, 32'h0,        4'd12}  // R12
  };

  task automatic chk(input int req, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL R%0d: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic cyc(input logic w, input logic r, input logic [15:0] a,
                     input logic [31:0] d, input logic [11:0] e, input logic [2:0] t);
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d; evt_set = e; thr_qual = t;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0; evt_set = '0; thr_qual = '0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    chk(8, {27'd0, act_upper_vld, irq_line}, 32'h0);  // R8 outputs idle
    chk(8, bus_rdata, 32'h0);                          // R8

    for (int i = 0; i < NV; i++) begin
      cyc(TBL[i].op == 2'd1, TBL[i].op == 2'd2, TBL[i].addr, TBL[i].data, TBL[i].evt, TBL[i].thr);
      if (TBL[i].op == 2'd2) chk(int'(TBL[i].req), bus_rdata, TBL[i].exp);
      if (TBL[i].op == 2'd3) chk(int'(TBL[i].req), {28'd0, irq_line}, TBL[i].exp);
    end

    // R1: rising edge only, no re-arm while level stays high
    port_rdy = 1;
    cyc(0, 0, 16'h0, 32'h0, 12'h0, 3'd0);
    cyc(0, 1, 16'h1008, 32'h0, 12'h0, 3'd0);
    chk(1, bus_rdata, 32'h4);
    cyc(1, 0, 16'h1008, 32'h4, 12'h0, 3'd0);
    cyc(0, 1, 16'h1008, 32'h0, 12'h0, 3'd0);
    chk(1, bus_rdata, 32'h0);
    port_rdy = 0;
    cyc(0, 0, 16'h0, 32'h0, 12'h0, 3'd0);
    cyc(0, 1, 16'h1008, 32'h0, 12'h0, 3'd0);
    chk(1, bus_rdata, 32'h0);
    port_rdy = 1;
    cyc(0, 0, 16'h0, 32'h0, 12'h0, 3'd0);
    cyc(0, 1, 16'h1008, 32'h0, 12'h0, 3'd0);
    chk(1, bus_rdata, 32'h4);
    cyc(1, 0, 16'h1008, 32'h4, 12'h0, 3'd0);

    // R11: set and clear on the same bit in one cycle
    cyc(1, 0, 16'h1008, 32'h2, 12'h002, 3'd0);
    cyc(0, 1, 16'h1008, 32'h0, 12'h0, 3'd0);
    chk(11, bus_rdata, 32'h2);
    cyc(1, 0, 16'h1008, 32'h2, 12'h0, 3'd0);

    // R9: activation gating
    act_lo_wr = 1; act64_en = 0;
    cyc(0, 0, 16'h0, 32'h0, 12'h0, 3'd0);
    chk(9, {31'd0, act_upper_vld}, 32'h0);
    act64_en = 1;
    cyc(0, 0, 16'h0, 32'h0, 12'h0, 3'd0);
    chk(9, {31'd0, act_upper_vld}, 32'h1);
    chk(9, act_upper, 32'h12345678);
    act_lo_wr = 0; act64_en = 0;
    cyc(0, 0, 16'h0, 32'h0, 12'h0, 3'd0);
    chk(9, {31'd0, act_upper_vld}, 32'h0);

    // R7: line D, other lines low
    cyc(0, 0, 16'h0, 32'h0, 12'h001, 3'd0);
    cyc(1, 0, 16'h1010, 32'hC0000000, 12'h0, 3'd0);
    cyc(0, 0, 16'h0, 32'h0, 12'h0, 3'd0);
    chk(7, {28'd0, irq_line}, 32'h8);
    cyc(1, 0, 16'h1008, 32'h1, 12'h0, 3'd0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule